// File: doc/BRIEF.md
# Latching Fault Register with Timed Release

This block holds the fault state of one protection channel. A raw fault condition, produced elsewhere by a threshold comparison, must be present for a set number of consecutive clocks before it can set the latch. Once set, the fault output stays high until software or system logic pulses a clear, or until an optional timed release completes. The timed release counts only while the raw condition is absent, and it restarts whenever the condition returns.

Each time the latch goes from idle to tripped, an 8-bit event counter advances. The counter stops at its maximum instead of wrapping, and only reset returns it to zero. Higher-level logic can use this count to choose a degraded operating mode when a channel trips over and over. Combining several channels and generating the raw condition are handled outside this block.

Top module: `fault_hold_latch`

## Requirements
- R1: Once `fault_out` is high, it stays high until `clear_in` is sampled high or a timed release completes.
- R2: A timed release never happens while `auto_en` is low. While `auto_en` is low, the release countdown stays loaded with `release_delay`.
- R3: With `auto_en` high and a delay of D, `fault_out` falls on the clock edge that ends the (D+1)-th consecutive cycle in which the fault is latched, `auto_en` is high and `cond_in` is low. With D = 0 it falls at the end of the first such cycle.
- R4: A cycle with `cond_in` high during the countdown reloads it to the full `release_delay`. Counting starts again from the next absent cycle.
- R5: `fault_out` rises on the edge after `cond_in` has been sampled high on DEBOUNCE_LEN consecutive edges. Any low sample restarts the debounce, so shorter pulses never set the latch.
- R6: `clear_in` has priority over a new trip in the same cycle. If the debounced condition is still present once clear drops, the latch sets again on the next edge.
- R7: `trip_count` advances by exactly one on each idle-to-tripped transition. It holds at 255 and is not changed by `clear_in`.
- R8: While `rst_n` is sampled low, `fault_out` goes to 0, `trip_count` goes to 0 and the debounce restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_in | input | 1 | Raw fault condition from the channel comparator |
| clear_in | input | 1 | Explicit fault clear, highest priority |
| auto_en | input | 1 | Enables the timed release |
| release_delay | input | 16 | Absent-condition cycles to wait before a timed release |
| fault_out | output | 1 | Latched fault |
| trip_count | output | 8 | Saturating count of latch events |

## Verification
`fault_out` rises DEBOUNCE_LEN+1 edges after the first high sample of `cond_in`, and `trip_count` advances on that same edge. A clear takes effect one edge after it is driven. A timed release lands exactly D+1 edges into an unbroken absent run. The bench drives inputs on falling edges and reads outputs on the next falling edge. For each result, it checks the output one edge before the due edge (still unchanged) and again on the due edge (changed), so an off-by-one in either direction is reported. The sweeps cover every pulse length up to twice the debounce length, every delay from 0 to 5, a reload in the middle of a countdown, and more than 255 trips.

// File: rtl/fhl_pkg.sv
// Shared types and default sizes for the fault hold latch.
package fhl_pkg;
    typedef enum logic {
        HOLD_IDLE    = 1'b0,
        HOLD_TRIPPED = 1'b1
    } hold_state_e;

    localparam int DEF_DELAY_W = 16;
    localparam int DEF_TRIP_W  = 8;
    localparam int DEF_DB_LEN  = 4;
endpackage

// File: rtl/fhl_debounce.sv
// Debounce: stable_o is high while raw_i has been sampled high on the
// last LEN consecutive edges. Assumes LEN >= 1 and synchronous raw_i.
module fhl_debounce #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic stable_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN);

    logic [CW-1:0] run_q;

    // Count consecutive high samples, saturating at LEN; a low sample restarts.
    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= '0;
        else if (!raw_i)      run_q <= '0;
        else if (run_q != TOP) run_q <= run_q + CW'(1);
    end

    assign stable_o = (run_q == TOP);

    AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_i |=> !stable_o); // R5
    AST_STABLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable_o) |-> $past(raw_i)); // R5
endmodule

// File: rtl/fhl_release_timer.sv
// Release timer: while the fault is latched, auto-release is enabled and
// the raw condition is absent, counts a loaded delay down to zero.
// expired_o marks the cycle in which the release may take effect.
// Assumes delay_i is steady while a countdown is in progress.
module fhl_release_timer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latched_i,
    input  logic          armed_i,
    input  logic          raw_i,
    input  logic [DW-1:0] delay_i,
    output logic          expired_o
);
    logic [DW-1:0] rem_q;
    logic          counting;

    assign counting = latched_i && armed_i && !raw_i;

    // Reload whenever counting is interrupted; otherwise step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              rem_q <= '0;
        else if (!counting)      rem_q <= delay_i;
        else if (rem_q != '0)    rem_q <= rem_q - DW'(1);
    end

    assign expired_o = counting && (rem_q == '0);

    AST_RELOAD_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_i && raw_i) |=> (rem_q == $past(delay_i))); // R4
    AST_NO_EXPIRE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |-> !expired_o); // R2
endmodule

// File: rtl/fhl_trip_counter.sv
// Trip counter: saturating event count, cleared only by reset.
module fhl_trip_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bump_i,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    // Add one per event until the maximum is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (bump_i && cnt_q != MAXV) cnt_q <= cnt_q + CW'(1);
    end

    assign count_o = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV)); // R7
    AST_STEP_OF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1))); // R7
endmodule

// File: rtl/fault_hold_latch.sv
// Fault hold latch for one protection channel: debounces the raw condition,
// latches it, releases on clear or a timed auto-release, and counts trips.
// Assumes inputs synchronous to clk; reset is synchronous and active low.
module fault_hold_latch
    import fhl_pkg::*;
#(
    parameter int DEBOUNCE_LEN = DEF_DB_LEN,
    parameter int DELAY_W      = DEF_DELAY_W,
    parameter int TRIP_W       = DEF_TRIP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cond_in,
    input  logic               clear_in,
    input  logic               auto_en,
    input  logic [DELAY_W-1:0] release_delay,
    output logic               fault_out,
    output logic [TRIP_W-1:0]  trip_count
);
    hold_state_e state_q;
    logic        stable;
    logic        expired;
    logic        set_evt;

    fhl_debounce #(.LEN(DEBOUNCE_LEN)) db_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (cond_in),
        .stable_o (stable)
    );

    fhl_release_timer #(.DW(DELAY_W)) rt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .latched_i (state_q == HOLD_TRIPPED),
        .armed_i   (auto_en),
        .raw_i     (cond_in),
        .delay_i   (release_delay),
        .expired_o (expired)
    );

    // A trip is taken only when idle, debounced, and not overridden by clear.
    assign set_evt = (state_q == HOLD_IDLE) && stable && !clear_in;

    fhl_trip_counter #(.CW(TRIP_W)) tc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (set_evt),
        .count_o (trip_count)
    );

    // Latch state: clear first, then set, then timed release.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     state_q <= HOLD_IDLE;
        else if (clear_in)                              state_q <= HOLD_IDLE;
        else if (set_evt)                               state_q <= HOLD_TRIPPED;
        else if (state_q == HOLD_TRIPPED && expired)    state_q <= HOLD_IDLE;
    end

    assign fault_out = (state_q == HOLD_TRIPPED);

    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_out && !clear_in && !expired) |=> fault_out); // R1
    AST_NO_AUTO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_out && !clear_in && !auto_en) |=> fault_out); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_in |=> !fault_out); // R6
    AST_SET_NEEDS_DEBOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_out) |-> $past(stable)); // R5
    AST_RISE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_out) && $past(trip_count) != {TRIP_W{1'b1}})
        |-> (trip_count == $past(trip_count) + TRIP_W'(1))); // R7
endmodule

// File: tb/fault_hold_latch_tb_top.sv
`timescale 1ns/1ps
module fault_hold_latch_tb_top;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cond_in = 1'b0;
    logic        clear_in = 1'b0;
    logic        auto_en = 1'b0;
    logic [15:0] release_delay = 16'd0;
    logic        fault_out;
    logic [7:0]  trip_count;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    fault_hold_latch #(.DEBOUNCE_LEN(N), .DELAY_W(16), .TRIP_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .clear_in(clear_in),
        .auto_en(auto_en), .release_delay(release_delay),
        .fault_out(fault_out), .trip_count(trip_count)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int bump(input int c);
        return (c >= 255) ? 255 : c + 1;
    endfunction

    // Hold the condition for N samples, then drop it; latch sets on that edge.
    task automatic latch_fault();
        cond_in = 1'b1;
        tick(N);
        cond_in = 1'b0;
        tick(1);
        exp_cnt = bump(exp_cnt);
    endtask

    task automatic pulse_clear();
        clear_in = 1'b1;
        tick(1);
        clear_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(2);
        // R8: reset state
        check("R8 fault after reset", fault_out, 0);
        check("R8 count after reset", trip_count, 0);
        rst_n = 1'b1;
        tick(1);

        // R5: pulse-length sweep
        for (int len = 1; len <= 2 * N; len++) begin
            cond_in = 1'b1;
            tick(len);
            if (len == N) check("R5 not yet set at N", fault_out, 0);
            cond_in = 1'b0;
            tick(1);
            check($sformatf("R5 pulse len %0d", len), fault_out, (len >= N) ? 1 : 0);
            if (len >= N) exp_cnt = bump(exp_cnt);
            check("R7 count after pulse", trip_count, exp_cnt);
            pulse_clear();
            check("R1 clear releases", fault_out, 0);
        end

        // R5: a low sample restarts the debounce
        cond_in = 1'b1; tick(N - 1);
        cond_in = 1'b0; tick(1);
        cond_in = 1'b1; tick(N - 1);
        cond_in = 1'b0; tick(2);
        check("R5 broken run ignored", fault_out, 0);
        check("R5 broken run not counted", trip_count, exp_cnt);

        // R1 and R2: hold with auto-release disabled
        auto_en = 1'b0;
        release_delay = 16'd0;
        latch_fault();
        tick(30);
        check("R1 holds without release", fault_out, 1);
        check("R2 no auto-release when disabled", fault_out, 1);
        auto_en = 1'b1;
        tick(1);
        check("R2 release once enabled", fault_out, 0);

        // R3: delay sweep
        for (int d = 0; d <= 5; d++) begin
            auto_en = 1'b1;
            release_delay = 16'(d);
            latch_fault();
            tick(d);
            check($sformatf("R3 still set, delay %0d", d), fault_out, 1);
            tick(1);
            check($sformatf("R3 released, delay %0d", d), fault_out, 0);
        end
        check("R7 count after delay sweep", trip_count, exp_cnt);

        // R4: condition returns mid-countdown
        release_delay = 16'd4;
        latch_fault();
        tick(2);
        cond_in = 1'b1;
        tick(1);
        cond_in = 1'b0;
        check("R4 held through return", fault_out, 1);
        tick(4);
        check("R4 reloaded, not yet released", fault_out, 1);
        tick(1);
        check("R4 released after full delay", fault_out, 0);

        // R6: clear beats a same-cycle trip
        auto_en = 1'b0;
        cond_in = 1'b1;
        tick(N);
        clear_in = 1'b1;
        tick(1);
        check("R6 clear beats trip", fault_out, 0);
        check("R6 no count on blocked trip", trip_count, exp_cnt);
        clear_in = 1'b0;
        tick(1);
        exp_cnt = bump(exp_cnt);
        check("R6 relatch after clear", fault_out, 1);
        check("R7 relatch counted", trip_count, exp_cnt);
        pulse_clear();
        check("R6 clear with condition present", fault_out, 0);
        tick(1);
        exp_cnt = bump(exp_cnt);
        check("R6 second relatch", fault_out, 1);
        cond_in = 1'b0;
        pulse_clear();

        // R7: saturation
        for (int k = 0; k < 258; k++) begin
            latch_fault();
            pulse_clear();
        end
        check("R7 saturates at 255", trip_count, 255);
        check("R7 model agrees", exp_cnt, 255);
        pulse_clear();
        check("R7 clear leaves count", trip_count, 255);

        // R8: reset in the middle of operation
        latch_fault();
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        check("R8 fault cleared by reset", fault_out, 0);
        check("R8 count cleared by reset", trip_count, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule